// File: doc/BRIEF.md
# Instruction Stream Cache Compressor

This block compresses a committed program-counter flow into short trace records. A detector watches the PC. It groups each sequential run of instructions into one stream, identified by the address where the stream starts and its instruction count. A stream closes when the flow jumps to a non-sequential address, or when the count reaches its ceiling. The closed descriptor then enters a small elastic buffer, so the processor is never stalled.

A set-associative stream cache drains the buffer. The set is chosen by hashing the start address with the length. When the descriptor is already cached, the block emits only its position (set and way) on the index channel. When it is not cached, the block emits the reserved position 0 on the index channel and the full descriptor on the miss channel. It then fills a victim way in the following cycle. Both channels use valid/ready handshakes. A sticky flag reports any descriptor lost because the buffer was full.

Top module: `isc_compressor`

## Requirements
- R1: After reset, idx_valid, miss_valid and buf_ovf are all 0, and every cache entry is empty.
- R2: The first PC after reset opens a stream of length 1. A PC that is not the previous PC plus 4 closes the open stream and opens a new one at that PC with length 1. Otherwise the length grows by 1.
- R3: A stream that reaches MAX_LEN instructions (default 255, in an 8-bit field) is closed when the next PC arrives, even when that PC is sequential. The next stream starts at that PC.
- R4: The set of a descriptor is pc bits [6:2] of its start address XOR the low 5 bits of its length. The index record is {set[4:0], way[1:0]}.
- R5: A descriptor that matches a valid entry in its set (both start address and length equal) produces one index record with that entry's position, and no miss record.
- R6: A descriptor with no match produces index value 0 and one miss record miss_data = {start[31:0], length[7:0]}. That descriptor hits when it is presented next, unless it has been evicted.
- R7: On a miss, the lowest-numbered empty way of the set is filled. Way 0 of set 0 is never filled, so index 0 always means a miss.
- R8: When no eligible way is empty, the eligible way that was least recently hit or filled is replaced.
- R9: A record whose ready is low stays valid with unchanged data. Records on each channel keep the order of the streams.
- R10: A descriptor that closes while the buffer is full is dropped, and buf_ovf rises and stays at 1 until reset.
- R11: The open stream produces no record until a later PC closes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_valid | input | 1 | A committed PC is present this cycle |
| pc | input | 32 | Committed program counter |
| idx_valid | output | 1 | Index record present |
| idx_ready | input | 1 | Consumer accepts the index record |
| idx_data | output | 7 | {set, way}, or 0 for a miss |
| miss_valid | output | 1 | Miss record present |
| miss_ready | input | 1 | Consumer accepts the miss record |
| miss_data | output | 40 | {start address, length} of a missed stream |
| buf_ovf | output | 1 | Sticky: a descriptor was dropped |

## Verification
A short loop repeated several times separates the first-time miss from later hits. It also shows that one jump both closes a stream and opens the next. Five streams hashed to one ordinary set, revisited in a chosen order, show whether the least recently used way is evicted rather than a fixed way. Four streams hashed to set 0 confirm that the reserved slot is never allocated. A straight run longer than the length ceiling tells a length cut apart from a jump cut. A periodic ready pattern, and then a full stall, exercise record holding and the overflow flag.

// File: rtl/isc_pkg.sv
package isc_pkg;
   typedef enum logic {
      ST_LOOK = 1'b0,
      ST_FILL = 1'b1
   } cache_st_e;
endpackage

// File: rtl/isc_stream_detect.sv
module isc_stream_detect #(
   parameter int ADDR_W  = 32,
   parameter int LEN_W   = 8,
   parameter int MAX_LEN = 255
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pc_valid,
   input  logic [ADDR_W-1:0] pc,
   output logic              push,
   output logic [ADDR_W-1:0] push_sa,
   output logic [LEN_W-1:0]  push_len
);
   localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);

   if (MAX_LEN < 2 || MAX_LEN > (2**LEN_W) - 1) begin : g_bad_len
      $error("MAX_LEN must fit the length field");
   end

   logic              open_q;
   logic [ADDR_W-1:0] prev_q, sa_q;
   logic [LEN_W-1:0]  len_q;
   logic              seq;

   always_comb begin
      seq      = (pc == prev_q + ADDR_W'(4));
      push     = pc_valid && open_q && (!seq || len_q == LEN_MAX);
      push_sa  = sa_q;
      push_len = len_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         prev_q <= '0;
         sa_q   <= '0;
         len_q  <= '0;
      end else if (pc_valid) begin
         prev_q <= pc;
         open_q <= 1'b1;
         if (!open_q || push) begin
            sa_q  <= pc;
            len_q <= LEN_W'(1);
         end else begin
            len_q <= len_q + LEN_W'(1);
         end
      end
   end

   p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      open_q |-> (len_q >= LEN_W'(1) && len_q <= LEN_MAX));
   p_new_stream_r2: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (len_q == LEN_W'(1) && sa_q == $past(pc)));
endmodule

// File: rtl/isc_desc_fifo.sv
module isc_desc_fifo #(
   parameter int WIDTH = 40,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             rd,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             ovf
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = PTR_W + 1;

   if (DEPTH < 2 || (1 << $clog2(DEPTH)) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0] wp_q, rp_q;
   logic [CNT_W-1:0] cnt_q;
   logic             full, wr_ok, rd_ok;

   always_comb begin
      full  = (cnt_q == CNT_W'(DEPTH));
      empty = (cnt_q == '0);
      rd_ok = rd && !empty;
      wr_ok = wr && (!full || rd_ok);
      rdata = mem_q[rp_q];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
         ovf   <= 1'b0;
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else begin
         if (wr_ok) begin
            mem_q[wp_q] <= wdata;
            wp_q        <= wp_q + PTR_W'(1);
         end
         if (rd_ok) rp_q <= rp_q + PTR_W'(1);
         cnt_q <= cnt_q + CNT_W'(wr_ok) - CNT_W'(rd_ok);
         if (wr && !wr_ok) ovf <= 1'b1;
      end
   end

   p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/isc_stream_cache.sv
module isc_stream_cache
   import isc_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int LEN_W    = 8,
   parameter int SETS     = 32,
   parameter int WAYS     = 4,
   parameter int HASH_LSB = 2
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  in_valid,
   input  logic [ADDR_W-1:0]                     in_sa,
   input  logic [LEN_W-1:0]                      in_len,
   output logic                                  in_pop,
   output logic                                  idx_valid,
   input  logic                                  idx_ready,
   output logic [$clog2(SETS)+$clog2(WAYS)-1:0]  idx_data,
   output logic                                  miss_valid,
   input  logic                                  miss_ready,
   output logic [ADDR_W+LEN_W-1:0]               miss_data
);
   localparam int SET_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);
   localparam int IDX_W = SET_W + WAY_W;

   if (SETS < 2 || WAYS < 2 || (1 << SET_W) != SETS || (1 << WAY_W) != WAYS) begin : g_bad_geom
      $error("SETS and WAYS must be powers of two, at least 2");
   end
   if (LEN_W < SET_W || HASH_LSB + SET_W > ADDR_W) begin : g_bad_hash
      $error("hash fields exceed the descriptor widths");
   end

   logic              v_q   [SETS][WAYS];
   logic [ADDR_W-1:0] sa_q  [SETS][WAYS];
   logic [LEN_W-1:0]  ln_q  [SETS][WAYS];
   logic [WAY_W-1:0]  age_q [SETS][WAYS];

   cache_st_e         st_q;
   logic [SET_W-1:0]  fset_q;
   logic [WAY_W-1:0]  fway_q;
   logic [ADDR_W-1:0] fsa_q;
   logic [LEN_W-1:0]  fln_q;

   logic [SET_W-1:0]  set_i;
   logic              hit, inv_hit, out_free, go, touch;
   logic [WAY_W-1:0]  hway, inv_way, old_way, vway, tway;
   logic [WAY_W-1:0]  old_age;
   logic [SET_W-1:0]  tset;

   always_comb begin
      set_i    = in_sa[HASH_LSB +: SET_W] ^ in_len[SET_W-1:0];
      out_free = (!idx_valid || idx_ready) && (!miss_valid || miss_ready);
      go       = in_valid && out_free && (st_q == ST_LOOK);
      in_pop   = go;
      hit  = 1'b0;
      hway = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (v_q[set_i][w] && sa_q[set_i][w] == in_sa && ln_q[set_i][w] == in_len) begin
            hit  = 1'b1;
            hway = WAY_W'(w);
         end
      end
      inv_hit = 1'b0;
      inv_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!(set_i == '0 && w == 0) && !v_q[set_i][w]) begin
            inv_hit = 1'b1;
            inv_way = WAY_W'(w);
         end
      end
      old_way = '0;
      old_age = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!(set_i == '0 && w == 0) && age_q[set_i][w] >= old_age) begin
            old_way = WAY_W'(w);
            old_age = age_q[set_i][w];
         end
      end
      vway  = inv_hit ? inv_way : old_way;
      touch = (go && hit) || (st_q == ST_FILL);
      tset  = (st_q == ST_FILL) ? fset_q : set_i;
      tway  = (st_q == ST_FILL) ? fway_q : hway;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
               v_q[s][w]   <= 1'b0;
               sa_q[s][w]  <= '0;
               ln_q[s][w]  <= '0;
               age_q[s][w] <= WAY_W'(w);
            end
         end
      end else begin
         if (st_q == ST_FILL) begin
            v_q[fset_q][fway_q]  <= 1'b1;
            sa_q[fset_q][fway_q] <= fsa_q;
            ln_q[fset_q][fway_q] <= fln_q;
         end
         if (touch) begin
            for (int w = 0; w < WAYS; w++) begin
               if (age_q[tset][w] < age_q[tset][tway]) age_q[tset][w] <= age_q[tset][w] + WAY_W'(1);
            end
            age_q[tset][tway] <= '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_LOOK;
         fset_q     <= '0;
         fway_q     <= '0;
         fsa_q      <= '0;
         fln_q      <= '0;
         idx_valid  <= 1'b0;
         idx_data   <= '0;
         miss_valid <= 1'b0;
         miss_data  <= '0;
      end else begin
         st_q <= ST_LOOK;
         if (idx_valid && idx_ready)   idx_valid  <= 1'b0;
         if (miss_valid && miss_ready) miss_valid <= 1'b0;
         if (go) begin
            idx_valid <= 1'b1;
            idx_data  <= hit ? {set_i, hway} : IDX_W'(0);
            if (!hit) begin
               miss_valid <= 1'b1;
               miss_data  <= {in_sa, in_len};
               st_q       <= ST_FILL;
               fset_q     <= set_i;
               fway_q     <= vway;
               fsa_q      <= in_sa;
               fln_q      <= in_len;
            end
         end
      end
   end

   p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_valid && !idx_ready) |=> (idx_valid && $stable(idx_data)));
   p_miss_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && !miss_ready) |=> (miss_valid && $stable(miss_data)));
   p_miss_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !hit) |=> (idx_valid && idx_data == '0 && miss_valid));
   p_reserved_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !v_q[0][0]);
   p_one_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({v_q[set_i][0] && sa_q[set_i][0] == in_sa && ln_q[set_i][0] == in_len,
                  v_q[set_i][1] && sa_q[set_i][1] == in_sa && ln_q[set_i][1] == in_len}) <= 1);
endmodule

// File: rtl/isc_compressor.sv
module isc_compressor #(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 8,
   parameter int MAX_LEN   = 255,
   parameter int SETS      = 32,
   parameter int WAYS      = 4,
   parameter int BUF_DEPTH = 4,
   parameter int HASH_LSB  = 2
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  pc_valid,
   input  logic [ADDR_W-1:0]                     pc,
   output logic                                  idx_valid,
   input  logic                                  idx_ready,
   output logic [$clog2(SETS)+$clog2(WAYS)-1:0]  idx_data,
   output logic                                  miss_valid,
   input  logic                                  miss_ready,
   output logic [ADDR_W+LEN_W-1:0]               miss_data,
   output logic                                  buf_ovf
);
   localparam int DESC_W = ADDR_W + LEN_W;

   logic              push, pop, empty;
   logic [ADDR_W-1:0] push_sa;
   logic [LEN_W-1:0]  push_len;
   logic [DESC_W-1:0] head;

   isc_stream_detect #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_detect (
      .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid), .pc(pc),
      .push(push), .push_sa(push_sa), .push_len(push_len));

   isc_desc_fifo #(.WIDTH(DESC_W), .DEPTH(BUF_DEPTH)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr(push), .wdata({push_sa, push_len}),
      .rd(pop), .rdata(head), .empty(empty), .ovf(buf_ovf));

   isc_stream_cache #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SETS(SETS), .WAYS(WAYS),
                      .HASH_LSB(HASH_LSB)) u_cache (
      .clk(clk), .rst_n(rst_n), .in_valid(!empty),
      .in_sa(head[DESC_W-1:LEN_W]), .in_len(head[LEN_W-1:0]), .in_pop(pop),
      .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_data(idx_data),
      .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_data(miss_data));

   p_ovf_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(buf_ovf) |-> $past(push));
endmodule

// File: tb/tb_isc_compressor.sv
`timescale 1ns/1ps
module tb_isc_compressor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pc_valid = 1'b0;
   logic [31:0] pc = '0;
   logic        idx_valid, miss_valid, buf_ovf;
   logic        idx_ready = 1'b1, miss_ready = 1'b1;
   logic [6:0]  idx_data;
   logic [39:0] miss_data;

   always #2 clk = ~clk;

   isc_compressor dut (
      .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid), .pc(pc),
      .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_data(idx_data),
      .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_data(miss_data),
      .buf_ovf(buf_ovf));

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   bit mon_en = 1;
   int rdy_mode = 0;   // 0 always ready, 1 periodic, 2 stalled
   int cyc = 0;

   int          exp_idx[$];
   logic [39:0] exp_miss[$];

   // reference model state
   bit          mv [32][4];
   logic [31:0] msa [32][4];
   logic [7:0]  mln [32][4];
   longint      mst [32][4];
   longint      tick = 0;
   bit          m_open = 0;
   logic [31:0] m_prev, m_sa;
   int          m_len;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int s = 0; s < 32; s++)
         for (int w = 0; w < 4; w++) begin mv[s][w] = 0; mst[s][w] = 0; end
      m_open = 0;
      exp_idx.delete();
      exp_miss.delete();
   endtask

   // R4 hash, R5 hit, R6 miss, R7 fill order, R8 least recently used
   task automatic model_lookup(input logic [31:0] sa, input int len);
      int set, way, vic;
      bit found;
      set = int'(((sa >> 2) ^ 32'(len)) & 32'd31);
      found = 0; way = 0;
      for (int w = 0; w < 4; w++)
         if (mv[set][w] && msa[set][w] == sa && mln[set][w] == 8'(len)) begin found = 1; way = w; end
      tick++;
      if (found) begin
         exp_idx.push_back(set * 4 + way);
         mst[set][way] = tick;
      end else begin
         exp_idx.push_back(0);
         exp_miss.push_back({sa, 8'(len)});
         vic = -1;
         for (int w = 3; w >= 0; w--)
            if (!(set == 0 && w == 0) && !mv[set][w]) vic = w;
         if (vic < 0) begin
            longint best;
            best = 64'h7fffffffffffffff;
            for (int w = 0; w < 4; w++)
               if (!(set == 0 && w == 0) && mst[set][w] < best) begin best = mst[set][w]; vic = w; end
         end
         mv[set][vic] = 1; msa[set][vic] = sa; mln[set][vic] = 8'(len); mst[set][vic] = tick;
      end
   endtask

   // R2 and R3 stream rules
   task automatic send_pc(input logic [31:0] a);
      @(negedge clk);
      pc_valid = 1'b1;
      pc = a;
      if (!m_open) begin
         m_open = 1; m_sa = a; m_len = 1;
      end else if (a != m_prev + 32'd4 || m_len == 255) begin
         model_lookup(m_sa, m_len);
         m_sa = a; m_len = 1;
      end else m_len++;
      m_prev = a;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         pc_valid = 1'b0;
      end
   endtask

   task automatic send_stream(input logic [31:0] sa, input int len);
      for (int i = 0; i < len; i++) send_pc(sa + 32'(4 * i));
      idle(2);
   endtask

   task automatic drain();
      for (int i = 0; i < 3000 && (exp_idx.size() != 0 || exp_miss.size() != 0); i++) idle(1);
      idle(4);
   endtask

   // scoreboard monitor, R9 hold and order
   logic        p_iv = 0, p_ir = 0, p_mv = 0, p_mr = 0;
   logic [6:0]  p_id;
   logic [39:0] p_md;
   always @(negedge clk) begin
      cyc++;
      idx_ready  = (rdy_mode == 0) || (rdy_mode == 1 && (cyc % 5) != 0 && (cyc % 7) != 3);
      miss_ready = (rdy_mode == 0) || (rdy_mode == 1 && (cyc % 3) != 1);
      if (rst_n && mon_en && !done) begin
         if (p_iv && !p_ir)
            check(idx_valid && idx_data == p_id, "R9 index held", {idx_valid, idx_data}, {1'b1, p_id});
         if (p_mv && !p_mr)
            check(miss_valid && miss_data == p_md, "R9 miss held", {miss_valid, miss_data}, {1'b1, p_md});
         if (idx_valid && idx_ready) begin
            if (exp_idx.size() == 0) check(0, "R5 R6 unexpected index", idx_data, 0);
            else begin
               int e;
               e = exp_idx.pop_front();
               check(int'(idx_data) == e, (e == 0) ? "R6 R7 miss index" : "R4 R5 R8 hit index", idx_data, e);
            end
         end
         if (miss_valid && miss_ready) begin
            if (exp_miss.size() == 0) check(0, "R6 unexpected miss", miss_data, 0);
            else begin
               logic [39:0] e;
               e = exp_miss.pop_front();
               check(miss_data == e, "R2 R3 R6 miss descriptor", miss_data, e);
            end
         end
      end
      p_iv = idx_valid; p_ir = idx_ready; p_id = idx_data;
      p_mv = miss_valid; p_mr = miss_ready; p_md = miss_data;
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      check(0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      model_reset();
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      check(!idx_valid && !miss_valid && !buf_ovf, "R1 reset outputs", {idx_valid, miss_valid, buf_ovf}, 0);

      // R2 R5 R6: loop body re-entered four times
      for (int k = 0; k < 4; k++) send_stream(32'h0000_1000, 8);
      drain();
      // R11: the open stream is still pending, nothing emitted
      check(!idx_valid && !miss_valid, "R11 open stream silent", {idx_valid, miss_valid}, 0);

      // R8: five streams in set 2 with periodic backpressure (R9)
      rdy_mode = 1;
      for (int k = 0; k < 4; k++) send_stream(32'h0000_2000 + 32'(k * 128), 2);
      send_stream(32'h0000_2000, 2);              // refresh k0
      send_stream(32'h0000_2000 + 32'(4 * 128), 2); // evicts k1
      send_stream(32'h0000_2000 + 32'(128), 2);     // k1 misses again
      send_stream(32'h0000_2000, 2);                // k0 still hits
      drain();

      // R7: set 0 offers only three ways
      for (int k = 0; k < 4; k++) send_stream(32'h0000_3010 + 32'(k * 128), 4);
      for (int k = 0; k < 4; k++) send_stream(32'h0000_3010 + 32'(k * 128), 4);
      drain();

      // R3: a long straight run cut at the length ceiling
      rdy_mode = 0;
      send_stream(32'h0000_8000, 300);
      send_stream(32'h0000_8000, 300);
      send_stream(32'h0000_9000, 3);
      drain();
      check(exp_idx.size() == 0, "R5 R6 index records complete", exp_idx.size(), 0);
      check(exp_miss.size() == 0, "R6 miss records complete", exp_miss.size(), 0);
      check(!buf_ovf, "R10 no overflow under normal rate", buf_ovf, 0);

      // R10: stalled consumer, streams keep closing
      mon_en = 0;
      rdy_mode = 2;
      for (int k = 0; k < 12; k++) send_pc(32'h0001_0000 + 32'(k * 64));
      idle(3);
      check(buf_ovf, "R10 overflow raised", buf_ovf, 1);
      check(idx_valid && miss_valid, "R9 stalled records held", {idx_valid, miss_valid}, 2'b11);
      rdy_mode = 0;
      idle(40);
      check(buf_ovf, "R10 overflow sticky", buf_ovf, 1);

      // R1 again after a second reset
      rst_n = 1'b0;
      idle(2);
      check(!idx_valid && !miss_valid && !buf_ovf, "R1 outputs after reset", {idx_valid, miss_valid, buf_ovf}, 0);
      rst_n = 1'b1;
      model_reset();
      mon_en = 1;
      send_stream(32'h0000_1000, 8);
      send_stream(32'h0000_1000, 8);
      drain();
      check(exp_idx.size() == 0, "R1 cache empty after reset", exp_idx.size(), 0);
      finish_run();
   end
endmodule